// File: doc/BRIEF.md
# DMA Channel Request Generator

This block decides, for each channel of a multi-channel DMA controller, whether that channel is currently asking for a transfer. Each channel has a 4-bit source selector that picks one of three request styles. The auto style asks continuously. The pin style watches an active-low request pin from outside the chip. The peripheral style follows one of six on-chip peripheral request lines. A channel only asks when its own enable is set and its end flag is clear, the global master enable is set, and the global abort flag is clear.

Request pins are brought into the clock domain through a two-stage synchroniser. Channels below `NUM_EDGE_CH` have a detect-select bit that picks low-level detection or falling-edge detection. A detected edge is held pending until the channel acknowledges it. The block also decodes the selector into an address mode and flags any selector/size combination that is not allowed. Arbitration, bus cycles, address counting and acknowledge timing belong to the surrounding controller.

Top module: `dma_req_gen`

## Requirements
- R1: A channel's `req` is 0 unless `ch_en` is 1, `ch_end` is 0, `gbl_en` is 1 and `gbl_abort` is 0. Dropping any one of these four terms removes the request in the same cycle.
- R2: Selector 4'b0100 is the auto style. While the four-term enable holds and the selector is legal, `req` is 1 with no external input.
- R3: Selectors 4'b0000, 4'b0010 and 4'b0011 are the pin style. In level detection, `req` follows the inverse of the channel's `dreq_n` pin with a latency of two rising clock edges.
- R4: On channels below `NUM_EDGE_CH` (channels 0 and 1), `ch_edge`=1 selects falling-edge detection. A falling edge of `dreq_n` sets a pending request that is visible three rising edges after the pin falls. It stays set after the pin returns high, and it is cleared by the edge at which `ack` is 1.
- R5: Channels at or above `NUM_EDGE_CH` always use level detection, and their `ch_edge` bit has no effect.
- R6: Selector 4'b1000+k, for k from 0 to 5, is the peripheral style. `req` follows `periph_req[k]` (active high) combinationally.
- R7: The peripheral style combined with `ch_size`=2'b11 (16-byte units) sets `cfg_err`, gives no request and reports address mode 2'b00.
- R8: `addr_mode` per channel (2 bits): 2'b01 dual-address for selectors 0000, 0100 and the peripheral codes; 2'b10 single-address memory-to-device for 0010; 2'b11 single-address device-to-memory for 0011; 2'b00 otherwise.
- R9: Selectors 0001, 0101, 0110, 0111, 1110 and 1111 set `cfg_err`, give no request and report address mode 2'b00.
- R10: Reset clears every pending edge request. A pending edge request is also cleared by the first rising edge at which the four-term enable does not hold, and it does not come back when the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_n | input | NUM_CH | Active-low external request pins, asynchronous |
| periph_req | input | NUM_PERIPH | Active-high on-chip peripheral request lines |
| ch_sel | input | NUM_CH*4 | Per-channel source selector, channel c at bits [4c+3:4c] |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_end | input | NUM_CH | Per-channel transfer-end flag |
| ch_edge | input | NUM_CH | Per-channel detect select, 1 = falling edge (low channels only) |
| ch_size | input | NUM_CH*2 | Per-channel transfer size, 2'b11 = 16-byte units |
| ack | input | NUM_CH | Per-channel acknowledge that clears a pending edge request |
| gbl_en | input | 1 | Global master enable |
| gbl_abort | input | 1 | Global abort flag, blocks all requests |
| req | output | NUM_CH | Per-channel request |
| addr_mode | output | NUM_CH*2 | Per-channel decoded address mode, channel c at bits [2c+1:2c] |
| cfg_err | output | NUM_CH | Per-channel illegal-configuration flag |

## Verification
Random configurations cover every selector code, both size classes, each state of the four enable terms, and random pin and peripheral levels held long enough to settle. These runs separate the auto, pin and peripheral paths and the legal from the illegal codes. They also show that the high channels ignore their detect bit. Directed sequences on channel 0 then walk a falling edge through the synchroniser. They separate a latched edge request from a level request by releasing the pin before the acknowledge. Further directed cases drop the abort flag and reset while a request is pending. A level-mode run on channel 2 pins down the two-edge latency.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
   localparam int SEL_W = 4;

   typedef enum logic [1:0] {
      AM_NONE    = 2'b00,
      AM_DUAL    = 2'b01,
      AM_MEM2DEV = 2'b10,
      AM_DEV2MEM = 2'b11
   } addr_mode_e;

   localparam logic [SEL_W-1:0] SEL_PIN_DUAL    = 4'b0000;
   localparam logic [SEL_W-1:0] SEL_PIN_M2D     = 4'b0010;
   localparam logic [SEL_W-1:0] SEL_PIN_D2M     = 4'b0011;
   localparam logic [SEL_W-1:0] SEL_AUTO        = 4'b0100;
   localparam logic [SEL_W-1:0] SEL_PERIPH_BASE = 4'b1000;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dma_req_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= {W{RST_VAL}};
         else if (s == 0) stage_q[s] <= d;
         else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dma_req_decode.sv
module dma_req_decode
   import dma_req_pkg::*;
#(
   parameter int                NUM_PERIPH = 6,
   parameter int                SIZE_W     = 2,
   parameter logic [SIZE_W-1:0] BIG_SIZE   = 2'b11,
   parameter int                IDX_W      = 3
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [SIZE_W-1:0] size,
   output logic              is_pin,
   output logic              is_auto,
   output logic              is_periph,
   output logic [IDX_W-1:0]  periph_idx,
   output addr_mode_e        mode,
   output logic              cfg_err
);
   if (NUM_PERIPH > (1 << (SEL_W-1))) begin : g_bad_periph
      $error("dma_req_decode: too many peripheral sources for selector field");
   end

   logic [SEL_W-1:0] off;

   always_comb begin
      is_pin     = 1'b0;
      is_auto    = 1'b0;
      is_periph  = 1'b0;
      mode       = AM_NONE;
      cfg_err    = 1'b0;
      off        = sel - SEL_PERIPH_BASE;
      periph_idx = IDX_W'(off);
      case (sel)
         SEL_PIN_DUAL: begin is_pin = 1'b1; mode = AM_DUAL;    end
         SEL_PIN_M2D:  begin is_pin = 1'b1; mode = AM_MEM2DEV; end
         SEL_PIN_D2M:  begin is_pin = 1'b1; mode = AM_DEV2MEM; end
         SEL_AUTO:     begin is_auto = 1'b1; mode = AM_DUAL;   end
         default: begin
            if (sel >= SEL_PERIPH_BASE && off < SEL_W'(NUM_PERIPH)) begin
               if (size == BIG_SIZE) begin
                  cfg_err = 1'b1;
               end else begin
                  is_periph = 1'b1;
                  mode      = AM_DUAL;
               end
            end else begin
               cfg_err = 1'b1;
            end
         end
      endcase
   end

   always_comb begin
      AST_ONE_STYLE: assert ($onehot0({is_pin, is_auto, is_periph, cfg_err}));  // R9
      AST_ERR_NO_MODE: assert (!cfg_err || mode == AM_NONE);                     // R7
   end
endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan #(
   parameter bit HAS_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_ok,
   input  logic is_pin,
   input  logic is_auto,
   input  logic periph_hit,
   input  logic edge_sel,
   input  logic dreq_s_n,
   input  logic ack,
   output logic req
);
   logic pin_req;

   if (HAS_EDGE) begin : g_edge
      logic prev_n;
      logic pend;
      logic fall;
      logic edge_on;

      assign fall    = prev_n & ~dreq_s_n;
      assign edge_on = en_ok & is_pin & edge_sel;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_n <= 1'b1;
         else        prev_n <= dreq_s_n;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pend <= 1'b0;
         else if (!edge_on) pend <= 1'b0;
         else if (fall)     pend <= 1'b1;
         else if (ack)      pend <= 1'b0;
      end

      assign pin_req = edge_sel ? pend : ~dreq_s_n;

      AST_PEND_CLR_DIS: assert property (@(posedge clk) disable iff (!rst_n)
         !en_ok |=> !pend);                                                     // R10
      AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (pend && edge_on && !ack) |=> pend);                                   // R4
      AST_PEND_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         (ack && !fall) |=> !pend);                                             // R4
   end else begin : g_level
      logic unused_level;
      assign unused_level = edge_sel ^ ack;
      assign pin_req = ~dreq_s_n;
   end

   assign req = en_ok & (is_auto | (is_pin & pin_req) | periph_hit);

   AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_ok |-> !req);                                                         // R1
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
   import dma_req_pkg::*;
#(
   parameter int                NUM_CH      = 4,
   parameter int                NUM_EDGE_CH = 2,
   parameter int                NUM_PERIPH  = 6,
   parameter int                SYNC_STAGES = 2,
   parameter int                SIZE_W      = 2,
   parameter logic [SIZE_W-1:0] BIG_SIZE    = 2'b11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        dreq_n,
   input  logic [NUM_PERIPH-1:0]    periph_req,
   input  logic [NUM_CH*SEL_W-1:0]  ch_sel,
   input  logic [NUM_CH-1:0]        ch_en,
   input  logic [NUM_CH-1:0]        ch_end,
   input  logic [NUM_CH-1:0]        ch_edge,
   input  logic [NUM_CH*SIZE_W-1:0] ch_size,
   input  logic [NUM_CH-1:0]        ack,
   input  logic                     gbl_en,
   input  logic                     gbl_abort,
   output logic [NUM_CH-1:0]        req,
   output logic [NUM_CH*2-1:0]      addr_mode,
   output logic [NUM_CH-1:0]        cfg_err
);
   localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

   if (NUM_EDGE_CH > NUM_CH) begin : g_bad_edge
      $error("dma_req_gen: NUM_EDGE_CH exceeds NUM_CH");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("dma_req_gen: NUM_CH must be positive");
   end

   logic [NUM_CH-1:0] dreq_s_n;

   dma_req_sync #(
      .W       (NUM_CH),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dreq_n),
      .q     (dreq_s_n)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic             is_pin, is_auto, is_periph, err, en_ok, hit;
      logic [IDX_W-1:0] idx;
      addr_mode_e       mode;

      dma_req_decode #(
         .NUM_PERIPH (NUM_PERIPH),
         .SIZE_W     (SIZE_W),
         .BIG_SIZE   (BIG_SIZE),
         .IDX_W      (IDX_W)
      ) u_dec (
         .sel        (ch_sel[c*SEL_W +: SEL_W]),
         .size       (ch_size[c*SIZE_W +: SIZE_W]),
         .is_pin     (is_pin),
         .is_auto    (is_auto),
         .is_periph  (is_periph),
         .periph_idx (idx),
         .mode       (mode),
         .cfg_err    (err)
      );

      assign en_ok = ch_en[c] & ~ch_end[c] & gbl_en & ~gbl_abort;
      assign hit   = is_periph & periph_req[idx];

      dma_req_chan #(
         .HAS_EDGE (c < NUM_EDGE_CH)
      ) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .en_ok      (en_ok),
         .is_pin     (is_pin),
         .is_auto    (is_auto),
         .periph_hit (hit),
         .edge_sel   (ch_edge[c]),
         .dreq_s_n   (dreq_s_n[c]),
         .ack        (ack[c]),
         .req        (req[c])
      );

      assign addr_mode[c*2 +: 2] = mode;
      assign cfg_err[c]          = err;

      AST_ERR_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_err[c] |-> !req[c]);                                               // R9
      AST_ABORT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         gbl_abort |-> !req[c]);                                                // R1
   end
endmodule

// File: tb/dma_req_gen_tb.sv
module dma_req_gen_tb;
   localparam int NCH = 4;
   localparam int NP  = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  dreq_n = '1;
   logic [NP-1:0]   periph_req = '0;
   logic [NCH*4-1:0] ch_sel = '0;
   logic [NCH-1:0]  ch_en = '0, ch_end = '0, ch_edge = '0, ack = '0;
   logic [NCH*2-1:0] ch_size = '0;
   logic            gbl_en = 1'b0, gbl_abort = 1'b0;
   logic [NCH-1:0]  req, cfg_err;
   logic [NCH*2-1:0] addr_mode;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   dma_req_gen u_dut (
      .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .periph_req(periph_req),
      .ch_sel(ch_sel), .ch_en(ch_en), .ch_end(ch_end), .ch_edge(ch_edge),
      .ch_size(ch_size), .ack(ack), .gbl_en(gbl_en), .gbl_abort(gbl_abort),
      .req(req), .addr_mode(addr_mode), .cfg_err(cfg_err)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // returns {err, mode[1:0], req} for a level-detect channel with settled pin
   function automatic logic [3:0] model(input logic [3:0] sel, input logic [1:0] size,
                                        input logic en, input logic pin_n,
                                        input logic [NP-1:0] per);
      logic r, e;
      logic [1:0] m;
      r = 1'b0; e = 1'b0; m = 2'b00;
      if (sel == 4'b0000)      begin m = 2'b01; r = ~pin_n; end
      else if (sel == 4'b0010) begin m = 2'b10; r = ~pin_n; end
      else if (sel == 4'b0011) begin m = 2'b11; r = ~pin_n; end
      else if (sel == 4'b0100) begin m = 2'b01; r = 1'b1; end
      else if (sel >= 4'b1000 && sel < 4'b1000 + NP) begin
         if (size == 2'b11) e = 1'b1;
         else begin m = 2'b01; r = per[sel - 4'b1000]; end
      end else e = 1'b1;
      return {e, m, r & en};
   endfunction

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_ch0_edge();
      ch_sel[3:0] = 4'b0000; ch_en[0] = 1'b1; ch_end[0] = 1'b0; ch_edge[0] = 1'b1;
      ch_size[1:0] = 2'b00;
   endtask

   initial begin
      #(5 * 150000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [3:0] exp;
      logic en;
      void'($urandom(32'h1d5c));
      cyc(3);
      check("R10 reset req", req, '0);
      rst_n = 1'b1;
      cyc(2);
      check("R1 all disabled", req, '0);

      // random trials with level detection on channels 0/1, random detect bit on 2/3
      for (int t = 0; t < 400; t++) begin
         for (int c = 0; c < NCH; c++) begin
            ch_sel[c*4 +: 4]  = 4'($urandom_range(0, 15));
            ch_size[c*2 +: 2] = 2'($urandom_range(0, 3));
            ch_en[c]   = ($urandom_range(0, 4) != 0);
            ch_end[c]  = ($urandom_range(0, 5) == 0);
            ch_edge[c] = (c >= 2) ? 1'($urandom_range(0, 1)) : 1'b0;
         end
         gbl_en     = ($urandom_range(0, 6) != 0);
         gbl_abort  = ($urandom_range(0, 6) == 0);
         dreq_n     = NCH'($urandom);
         periph_req = NP'($urandom);
         cyc(3);
         for (int c = 0; c < NCH; c++) begin
            en  = ch_en[c] & ~ch_end[c] & gbl_en & ~gbl_abort;
            exp = model(ch_sel[c*4 +: 4], ch_size[c*2 +: 2], en, dreq_n[c], periph_req);
            check("R1 R2 R3 R5 R6 req", req[c], exp[0]);
            check("R8 addr_mode", addr_mode[c*2 +: 2], exp[2:1]);
            check("R7 R9 cfg_err", cfg_err[c], exp[3]);
         end
      end

      // directed: illegal codes and 16-byte peripheral
      gbl_en = 1'b1; gbl_abort = 1'b0; ch_en = '1; ch_end = '0; ch_edge = '0;
      periph_req = '1; dreq_n = '0;
      ch_sel = {4'b1111, 4'b1110, 4'b0101, 4'b0001};
      #1;
      check("R9 illegal codes err", cfg_err, 4'b1111);
      check("R9 illegal codes req", req, 4'b0000);
      ch_sel = {4'b1101, 4'b1000, 4'b1101, 4'b1000}; ch_size = {2'b11, 2'b11, 2'b10, 2'b00};
      #1;
      check("R7 periph size16 err", cfg_err, 4'b1100);
      check("R7 periph size16 req", req, 4'b0011);
      check("R7 periph size16 mode", addr_mode, 8'b00_00_01_01);

      // R5 level latency on channel 2 with detect bit set
      ch_sel = '0; ch_size = '0; dreq_n = '1; ch_edge = 4'b0100;
      cyc(3);
      dreq_n[2] = 1'b0;
      cyc(1);
      check("R5 ch2 after 1 edge", req[2], 1'b0);
      cyc(1);
      check("R3 R5 ch2 after 2 edges", req[2], 1'b1);
      dreq_n[2] = 1'b1;
      cyc(2);
      check("R3 R5 ch2 released", req[2], 1'b0);

      // R4 edge on channel 0
      ch_edge = '0; set_ch0_edge();
      cyc(3);
      dreq_n[0] = 1'b0;
      cyc(2);
      check("R4 edge not yet", req[0], 1'b0);
      cyc(1);
      check("R4 edge latched", req[0], 1'b1);
      dreq_n[0] = 1'b1;
      cyc(3);
      check("R4 held after pin release", req[0], 1'b1);
      ack[0] = 1'b1;
      cyc(1);
      ack[0] = 1'b0;
      check("R4 cleared by ack", req[0], 1'b0);
      cyc(2);
      check("R4 stays clear", req[0], 1'b0);

      // R10 abort clears pending
      dreq_n[0] = 1'b0;
      cyc(3);
      check("R4 second edge", req[0], 1'b1);
      gbl_abort = 1'b1;
      #1;
      check("R1 abort gates", req[0], 1'b0);
      cyc(1);
      gbl_abort = 1'b0;
      #1;
      check("R10 pending cleared by abort", req[0], 1'b0);

      // R10 reset clears pending
      dreq_n[0] = 1'b1;
      cyc(3);
      dreq_n[0] = 1'b0;
      cyc(3);
      check("R4 third edge", req[0], 1'b1);
      rst_n = 1'b0;
      cyc(1);
      rst_n = 1'b1;
      #1;
      check("R10 reset clears pending", req[0], 1'b0);
      cyc(1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule